// File: doc/BRIEF.md
# Shoot-through PWM modulator

This block drives the six gates of one three-phase bridge in an impedance-source inverter. It takes three signed phase references, normalized so that unity equals the carrier peak, and a shoot-through ratio in the same units. It ranks the references into largest, middle and smallest, adds a min-max centring offset to all three, and derives two references per leg: one for the upper switch and one for the lower switch. Each pair is offset by fixed fractions of the shoot-through ratio. Both references of a pair are compared against one shared symmetric triangle carrier.

Because the upper and lower references of a leg are offset from each other, each leg gets a short both-on window next to its switching instant. This window is where the upper switch turns on early, before the lower switch turns off. Only one leg is ever shorted at a time. Outside these windows the active-state timing is the same as in an ordinary centred two-level modulator. With a ratio of zero the gates fall back to plain complementary continuous PWM.

References and ratio are sampled only at a carrier turning point, so every gate makes at most one on and one off transition per period.

Top module: `stz_modulator`

## Requirements
- R1: The carrier is a triangle that counts up by one from -CMAX to +CMAX and back down, with period 4·CMAX clock cycles. CMAX = 2^HALF_W, which is 16 by default. After reset it starts at -CMAX, moving up.
- R2: Every reference gets the offset -floor((vmax+vmin)/2). To rank the phases, a phase outranks another if its value is greater; on equal values, A outranks B and B outranks C. The highest rank is max, the next is mid, the last is min.
- R3: Upper-switch references are: max phase v+off+S, mid phase v+off+S3, min phase v+off-S3. Here S is the latched ratio and S3 = floor(S/3).
- R4: Lower-switch references are: max phase v+off+S3, mid phase v+off-S3, min phase v+off-S.
- R5: The upper gate of a leg is high when its reference is greater than the carrier. The lower gate is high when its reference is less than or equal to the carrier. Gates are registered, one cycle behind the carrier. Bit 0 is phase A, bit 1 is B, bit 2 is C.
- R6: References and ratio are captured only in cycles when the carrier equals +CMAX or -CMAX. An input change at any other time has no effect on the gates until the next capture.
- R7: With a captured ratio of zero, the two gates of every leg are complementary in every cycle.
- R8: At most one leg has both gates high in any cycle, and no leg ever has both gates low.
- R9: Each gate changes state at most twice per carrier period. It changes exactly twice when its duty is neither 0 nor full.
- R10: While reset is low, all six gates are low. The captured references and ratio clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one carrier step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_a | input | REF_W | Phase A reference, signed, unity = CMAX |
| ref_b | input | REF_W | Phase B reference, signed |
| ref_c | input | REF_W | Phase C reference, signed |
| st_ratio | input | ST_W | Shoot-through ratio, unsigned, unity = CMAX |
| gate_hi | output | 3 | Upper-switch gates, bit 0 = phase A |
| gate_lo | output | 3 | Lower-switch gates, bit 0 = phase A |

## Verification
The main function is measured as duty counts over one full carrier period, so the result does not depend on carrier phase. It is tried with several reference patterns:
- all-zero references, which exercise the tie-break order;
- a balanced set with ratio zero, which isolates the centring offset and complementary fallback;
- asymmetric sets with each phase taking a different rank, which separate the max, mid and min shift rules;
- two equal references, which probe the ranking under ties;
- a near-full-scale set with a large ratio, which drives references past the carrier peak and forces saturated duties.

A directed sequence changes the inputs mid-ramp after a known reset phase. It shows the old values still in effect until the carrier peak and the new values after it.

// File: rtl/stz_pkg.sv
// Shared types for the shoot-through modulator.
// Assumes exactly three phases; ranks are max, mid, min in that order.
package stz_pkg;
    localparam int NPH = 3;
    typedef enum logic [1:0] {RK_MAX = 2'd0, RK_MID = 2'd1, RK_MIN = 2'd2} rank_e;
endpackage

// File: rtl/stz_carrier.sv
// Symmetric up/down triangle carrier from -CMAX to +CMAX, one step per clock.
// Assumes CW is wide enough to hold +/-CMAX as a signed value.
module stz_carrier #(
    parameter int HALF_W = 4,
    parameter int CW     = HALF_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic signed [CW-1:0] car,
    output logic                 at_turn
);
    localparam logic signed [CW-1:0] C_TOP = CW'(2 ** HALF_W);
    localparam logic signed [CW-1:0] C_BOT = -C_TOP;

    logic going_up;

    // Step the count and reverse direction on reaching either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car      <= C_BOT;
            going_up <= 1'b1;
        end else if (going_up) begin
            car <= car + 1'b1;
            if (car + 1'b1 == C_TOP) going_up <= 1'b0;
        end else begin
            car <= car - 1'b1;
            if (car - 1'b1 == C_BOT) going_up <= 1'b1;
        end
    end

    // Flag the peak and valley cycles.
    assign at_turn = (car == C_TOP) || (car == C_BOT);
endmodule

// File: rtl/stz_shaper.sv
// Ranks three references, applies the min-max centring offset and forms
// the upper and lower per-leg references shifted by the shoot-through ratio.
// Purely combinational; EW must exceed REF_W and ST_W by enough headroom.
module stz_shaper
    import stz_pkg::*;
#(
    parameter int REF_W = 6,
    parameter int ST_W  = 5,
    parameter int EW    = REF_W + 3
) (
    input  logic [NPH-1:0][REF_W-1:0] refs,
    input  logic [ST_W-1:0]           st,
    output logic [NPH-1:0][EW-1:0]    ru,
    output logic [NPH-1:0][EW-1:0]    rl
);
    logic signed [EW-1:0] vx [NPH];
    rank_e                rank [NPH];
    logic signed [EW-1:0] vmax, vmin, vsum, voff;
    logic signed [EW-1:0] s_full, s_third;
    logic [ST_W-1:0]      st_div3;

    // Sign-extend the references into the working width.
    always_comb begin
        for (int i = 0; i < NPH; i++) vx[i] = EW'($signed(refs[i]));
    end

    // Rank each phase by counting the phases that outrank it.
    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            logic [1:0] beat;
            beat = 2'd0;
            for (int j = 0; j < NPH; j++) begin
                if (j != i && (vx[j] > vx[i] || (vx[j] == vx[i] && j < i)))
                    beat = beat + 2'd1;
            end
            rank[i] = rank_e'(beat);
        end
    end

    // Pick the largest and smallest values and form the centring offset.
    always_comb begin
        vmax = '0;
        vmin = '0;
        for (int i = 0; i < NPH; i++) begin
            if (rank[i] == RK_MAX) vmax = vx[i];
            if (rank[i] == RK_MIN) vmin = vx[i];
        end
        vsum = vmax + vmin;
        voff = -(vsum >>> 1);
    end

    // Widen the full and one-third ratio shifts.
    always_comb begin
        st_div3 = st / ST_W'(3);
        s_full  = $signed({{(EW-ST_W){1'b0}}, st});
        s_third = $signed({{(EW-ST_W){1'b0}}, st_div3});
    end

    // Apply the rank-dependent shifts to the upper and lower references.
    always_comb begin
        for (int i = 0; i < NPH; i++) begin
            unique case (rank[i])
                RK_MAX: begin
                    ru[i] = vx[i] + voff + s_full;
                    rl[i] = vx[i] + voff + s_third;
                end
                RK_MID: begin
                    ru[i] = vx[i] + voff + s_third;
                    rl[i] = vx[i] + voff - s_third;
                end
                default: begin
                    ru[i] = vx[i] + voff - s_third;
                    rl[i] = vx[i] + voff - s_full;
                end
            endcase
        end
    end
endmodule

// File: rtl/stz_leg.sv
// One bridge leg: compares its upper and lower references with the
// carrier and registers both gates. Gates are held low in reset.
module stz_leg #(
    parameter int EW = 9,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] ru,
    input  logic [EW-1:0] rl,
    input  logic [CW-1:0] car,
    output logic          hi,
    output logic          lo
);
    logic signed [EW-1:0] car_x;

    // Sign-extend the carrier to the reference width.
    assign car_x = EW'($signed(car));

    // Register the two comparator decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= 1'b0;
            lo <= 1'b0;
        end else begin
            hi <= $signed(ru) > car_x;
            lo <= $signed(rl) <= car_x;
        end
    end
endmodule

// File: rtl/stz_modulator.sv
// Shoot-through carrier PWM for one three-phase bridge. Captures references
// and ratio at carrier turning points, shapes six references and compares
// them against the shared carrier. Unity scale equals the carrier peak.
module stz_modulator
    import stz_pkg::*;
#(
    parameter int HALF_W = 4,
    parameter int REF_W  = HALF_W + 2,
    parameter int ST_W   = HALF_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    input  logic        [ST_W-1:0]  st_ratio,
    output logic        [2:0]       gate_hi,
    output logic        [2:0]       gate_lo
);
    localparam int CW = HALF_W + 2;
    localparam int EW = REF_W + 3;

    logic signed [CW-1:0]      car;
    logic                      at_turn;
    logic [NPH-1:0][REF_W-1:0] lat_refs;
    logic [ST_W-1:0]           lat_st;
    logic [NPH-1:0][EW-1:0]    ru, rl;

    stz_carrier #(.HALF_W(HALF_W), .CW(CW)) i_carrier (
        .clk(clk), .rst_n(rst_n), .car(car), .at_turn(at_turn)
    );

    // Capture inputs only at the carrier peak or valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_refs <= '0;
            lat_st   <= '0;
        end else if (at_turn) begin
            lat_refs <= {ref_c, ref_b, ref_a};
            lat_st   <= st_ratio;
        end
    end

    stz_shaper #(.REF_W(REF_W), .ST_W(ST_W), .EW(EW)) i_shaper (
        .refs(lat_refs), .st(lat_st), .ru(ru), .rl(rl)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        stz_leg #(.EW(EW), .CW(CW)) i_leg (
            .clk(clk), .rst_n(rst_n), .ru(ru[p]), .rl(rl[p]),
            .car(car), .hi(gate_hi[p]), .lo(gate_lo[p])
        );
    end
endmodule

// File: rtl/stz_modulator_chk.sv
// Assertion checker bound to stz_modulator; observes carrier, captured
// inputs and gates. Checks start one cycle after reset is released.
module stz_modulator_chk #(
    parameter int CW    = 6,
    parameter int REF_W = 6,
    parameter int ST_W  = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic signed [CW-1:0]  car,
    input logic [2:0][REF_W-1:0] lat_refs,
    input logic [ST_W-1:0]       lat_st,
    input logic [2:0]            gate_hi,
    input logic [2:0]            gate_lo
);
    localparam logic signed [CW-1:0] C_TOP = CW'(2 ** (CW - 2));
    localparam logic signed [CW-1:0] C_BOT = -C_TOP;

    logic primed;

    // Mark the cycles after the first post-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_carrier_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        car <= C_TOP && car >= C_BOT);

    p_carrier_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (car == $past(car) + 1'b1) || (car == $past(car) - 1'b1));

    p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(car) != C_TOP && $past(car) != C_BOT)
        |-> ($stable(lat_refs) && $stable(lat_st)));

    p_zero_ratio_comp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(lat_st) == '0) |-> ((gate_hi ^ gate_lo) == 3'b111));

    p_single_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> $countones(gate_hi & gate_lo) <= 1);

    p_leg_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> ((gate_hi | gate_lo) == 3'b111));
endmodule

bind stz_modulator stz_modulator_chk #(.CW(CW), .REF_W(REF_W), .ST_W(ST_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .car(car), .lat_refs(lat_refs),
    .lat_st(lat_st), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/test_stz_modulator.sv
// Self-checking bench: vector table of reference sets measured as duty per
// carrier period, then directed reset and capture-timing tests.
module test_stz_modulator;
    localparam int HALF_W = 4;
    localparam int CM     = 2 ** HALF_W;
    localparam int PER    = 4 * CM;
    localparam int NV     = 7;
    // columns: ref_a, ref_b, ref_c, st_ratio
    localparam int VEC [NV][4] = '{
        '{  0,   0,   0,  0},
        '{ 12,  -6,  -6,  0},
        '{  8,  -3,  -5,  6},
        '{-10,  14,   2,  9},
        '{  5,   5, -10,  3},
        '{ 15, -15,   0, 12},
        '{  0,   0,   0, 15}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [5:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic [4:0] st_ratio = '0;
    logic [2:0] gate_hi, gate_lo;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stz_modulator #(.HALF_W(HALF_W)) i_stz_modulator (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .st_ratio(st_ratio), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Carrier values below r over one period (R1 carrier shape).
    function automatic int below(input int r);
        if (r <= -CM) return 0;
        if (r > CM)   return PER;
        return 2 * r + 2 * CM - 1;
    endfunction

    // Expected shaped references from R2, R3, R4.
    function automatic void shape(input int v[3], input int s,
                                  output int ru[3], output int rl[3]);
        int rk[3];
        int vmax, vmin, off, s3;
        vmax = 0; vmin = 0;
        for (int i = 0; i < 3; i++) begin
            rk[i] = 0;
            for (int j = 0; j < 3; j++)
                if (j != i && (v[j] > v[i] || (v[j] == v[i] && j < i))) rk[i]++;
            if (rk[i] == 0) vmax = v[i];
            if (rk[i] == 2) vmin = v[i];
        end
        off = -((vmax + vmin) >>> 1);
        s3 = s / 3;
        for (int i = 0; i < 3; i++) begin
            case (rk[i])
                0: begin ru[i] = v[i] + off + s;  rl[i] = v[i] + off + s3; end
                1: begin ru[i] = v[i] + off + s3; rl[i] = v[i] + off - s3; end
                default: begin ru[i] = v[i] + off - s3; rl[i] = v[i] + off - s; end
            endcase
        end
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit hs [PER][3];
        bit ls [PER][3];
        int v[3], eu[3], el[3];

        // R10: gates low during reset
        repeat (4) @(negedge clk);
        chk("R10 gate_hi in reset", gate_hi, 0);
        chk("R10 gate_lo in reset", gate_lo, 0);

        // R6: known carrier phase after release; change inputs mid-ramp
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        ref_a = -14; ref_b = 7; ref_c = 7; st_ratio = 0;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R6 old capture still in effect, gate_hi[0]", gate_hi[0], 1);
        repeat (32) @(posedge clk);
        @(negedge clk);
        chk("R6 new capture after peak, gate_hi[1]", gate_hi[1], 1);
        chk("R6 new capture after peak, gate_lo[1]", gate_lo[1], 0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            int nst, ncomp;
            ref_a = 6'(VEC[k][0]); ref_b = 6'(VEC[k][1]); ref_c = 6'(VEC[k][2]);
            st_ratio = 5'(VEC[k][3]);
            repeat (PER * 2 + 12) @(negedge clk);
            nst = 0; ncomp = 0;
            for (int s = 0; s < PER; s++) begin
                @(negedge clk);
                for (int p = 0; p < 3; p++) begin
                    hs[s][p] = gate_hi[p];
                    ls[s][p] = gate_lo[p];
                end
                if ($countones(gate_hi & gate_lo) > 1) nst++;
                if ((gate_hi ^ gate_lo) != 3'b111) ncomp++;
            end
            v[0] = VEC[k][0]; v[1] = VEC[k][1]; v[2] = VEC[k][2];
            shape(v, VEC[k][3], eu, el);
            for (int p = 0; p < 3; p++) begin
                int cu, cl, tu, tl, xu, xl;
                cu = 0; cl = 0; tu = 0; tl = 0;
                for (int s = 0; s < PER; s++) begin
                    cu += int'(hs[s][p]);
                    cl += int'(ls[s][p]);
                    if (hs[s][p] != hs[(s + PER - 1) % PER][p]) tu++;
                    if (ls[s][p] != ls[(s + PER - 1) % PER][p]) tl++;
                end
                xu = below(eu[p]);
                xl = PER - below(el[p]);
                chk($sformatf("R2 R3 R5 upper duty v%0d ph%0d", k, p), cu, xu);
                chk($sformatf("R2 R4 R5 lower duty v%0d ph%0d", k, p), cl, xl);
                chk($sformatf("R9 upper edges v%0d ph%0d", k, p), tu,
                    (xu == 0 || xu == PER) ? 0 : 2);
                chk($sformatf("R9 lower edges v%0d ph%0d", k, p), tl,
                    (xl == 0 || xl == PER) ? 0 : 2);
            end
            chk($sformatf("R8 multi-leg short cycles v%0d", k), nst, 0);
            if (VEC[k][3] == 0)
                chk($sformatf("R7 non-complementary cycles v%0d", k), ncomp, 0);
        end

        // R10: reset during operation forces gates low again
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 gate_hi after re-reset", gate_hi, 0);
        chk("R10 gate_lo after re-reset", gate_lo, 0);

        // R1: after release the carrier restarts at the valley. With zero
        // inputs captured, upper gates are on for exactly CM cycles of the
        // first up-ramp, then off.
        ref_a = 0; ref_b = 0; ref_c = 0; st_ratio = 0;
        @(negedge clk) rst_n = 1'b1;
        repeat (CM) @(posedge clk);
        @(negedge clk);
        chk("R1 upper A on at carrier -1", gate_hi[0], 1);
        @(posedge clk);
        @(negedge clk);
        chk("R1 upper A off at carrier 0", gate_hi[0], 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule